// File: doc/BRIEF.md
# Destination Address Filter Table

This block decides, for each received Ethernet frame, whether the frame is kept, by looking only at its 48-bit destination address. It holds a small table of station addresses. Each address has its own enable bit. Three global switches set the policy: compare against the table, take every group-addressed (multicast) frame, and take every all-stations (broadcast) frame. The first table slot is meant for the station's own address; the others are free for extra unicast or group addresses.

The address comes in one of two ways. The receive path can hand it over byte by byte as the frame starts, first octet first. Or a parser can hand over the whole 48-bit value with a one-cycle strobe. One cycle after the address is complete, the block gives a verdict: a keep flag, a flag saying that a table slot matched, and the index of that slot. Software or a configuration engine fills the table through a plain write-only register port. The block does not touch frame reception, checksums or buffering.

Top module: `addr_filter_cam`

## Requirements
- R1: After reset every table word, every enable bit and every policy switch is zero, no verdict is signalled, and a lookup of any address is rejected with no slot hit.
- R2: Slot i has two registers on the write port. The word at index 2*i holds address octet 0 in bits 31:24, octet 1 in 23:16, octet 2 in 15:8 and octet 3 in 7:0. The word at index 2*i+1 holds octet 4 in bits 31:24 and octet 5 in 23:16, and its bits 15:0 are ignored. Octet 0 is the first octet on the wire.
- R3: The enable register at index 2*N_ENTRIES has one bit per slot, bit i for slot i. A slot with its bit clear never matches, whatever address it holds.
- R4: The policy register at index 2*N_ENTRIES+1 uses bit 0 for table compare, bit 1 for keep-all-multicast and bit 2 for keep-all-broadcast. Its other bits are ignored.
- R5: With keep-all-broadcast set, the all-ones address is kept. With the switch clear, the all-ones address is not kept because of its broadcast nature.
- R6: With keep-all-multicast set, every address whose octet 0 has bit 0 set is kept, the all-ones address included. Unicast addresses are not kept by this switch.
- R7: The keep flag is the OR of three terms: broadcast with its switch set, multicast with its switch set, and a slot hit. A slot hit is reported only while table compare is set; with compare clear, a stored address gives neither a hit nor a keep.
- R8: When several enabled slots hold the looked-up address, the lowest index is reported. When there is no hit, the index output reads 0.
- R9: A parallel strobe gives a verdict pulse (dec_vld) in the next cycle. The lookup uses the table as it stood before any register write made in the same cycle. In cycles with no verdict, dec_vld, dec_accept, dec_hit and dec_idx are all 0.
- R10: In serial input, a byte flagged as start of frame is octet 0. The next five valid bytes are octets 1 to 5, and idle cycles may fall between them. The verdict appears in the cycle after the sixth byte, and not before.
- R11: Bytes after the sixth and valid bytes seen before any start-of-frame flag produce no verdict. A new start-of-frame flag part-way through an address drops the partial address and starts again at octet 0.
- R12: When a parallel strobe and the sixth serial byte arrive in the same cycle, only the parallel address is judged and exactly one verdict pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | $clog2(2*N_ENTRIES+2) | Register index |
| cfg_wdata | input | 32 | Register write data |
| da_vld | input | 1 | Parallel destination address strobe |
| da | input | 48 | Parallel destination address, octet 0 in bits 47:40 |
| rx_vld | input | 1 | Serial byte valid |
| rx_sof | input | 1 | Marks the serial byte as octet 0 of a frame |
| rx_byte | input | 8 | Serial address byte |
| dec_vld | output | 1 | Verdict pulse |
| dec_accept | output | 1 | Frame is kept |
| dec_hit | output | 1 | An enabled table slot matched with compare on |
| dec_idx | output | max(1,$clog2(N_ENTRIES)) | Lowest matching slot index |

## Verification
The bench builds the block with its defaults: sixteen slots and the serial front end present. This sizes the register file at 34 words with a 6-bit index. Those values make it possible to test the highest slot (index 15), the full 16-bit enable bitmap with ignored upper bits, and a duplicate address in slots 5 and 9 for the priority rule. Because the serial front end is present, the bench can place a sixth serial byte and a parallel strobe in the same cycle to test the arbitration between the two inputs.

// File: rtl/afc_pkg.sv
`timescale 1ns/1ps
package afc_pkg;
   localparam int unsigned MAC_W     = 48;
   localparam int unsigned WORD_W    = 32;
   localparam int unsigned OCTET_W   = 8;
   localparam int unsigned OCTET_CNT = MAC_W / OCTET_W;
   localparam int unsigned LO_KEEP_W = MAC_W - WORD_W;
   localparam int unsigned CTL_W     = 3;

   // bit 0 compare, bit 1 keep multicast, bit 2 keep broadcast
   typedef struct packed {
      logic all_bcast;
      logic all_mcast;
      logic cmp_en;
   } afc_ctl_t;

   function automatic logic addr_is_bcast(input logic [MAC_W-1:0] a);
      return &a;
   endfunction

   // group bit is the lsb of the first octet on the wire
   function automatic logic addr_is_mcast(input logic [MAC_W-1:0] a);
      return a[MAC_W-OCTET_W];
   endfunction
endpackage

// File: rtl/afc_table.sv
`timescale 1ns/1ps
module afc_table #(
   parameter int unsigned N_ENTRIES = 16,
   parameter int unsigned CFG_AW    = 6
) (
   input  logic                                              clk,
   input  logic                                              rst_n,
   input  logic                                              cfg_we,
   input  logic [CFG_AW-1:0]                                 cfg_addr,
   input  logic [afc_pkg::WORD_W-1:0]                        cfg_wdata,
   output logic [N_ENTRIES-1:0][afc_pkg::WORD_W-1:0]         tbl_hi,
   output logic [N_ENTRIES-1:0][afc_pkg::LO_KEEP_W-1:0]      tbl_lo,
   output logic [N_ENTRIES-1:0]                              ent_en,
   output afc_pkg::afc_ctl_t                                 ctl
);
   import afc_pkg::*;

   localparam int unsigned EN_SEL  = 2 * N_ENTRIES;
   localparam int unsigned CTL_SEL = 2 * N_ENTRIES + 1;

   if ((1 << CFG_AW) < CTL_SEL + 1) begin : g_aw_chk
      $error("afc_table: CFG_AW too narrow for the register file");
   end

   for (genvar i = 0; i < N_ENTRIES; i++) begin : g_slot
      localparam logic [CFG_AW-1:0] HI_SEL = CFG_AW'(2 * i);
      localparam logic [CFG_AW-1:0] LO_SEL = CFG_AW'(2 * i + 1);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tbl_hi[i] <= '0;
            tbl_lo[i] <= '0;
         end else if (cfg_we) begin
            if (cfg_addr == HI_SEL) tbl_hi[i] <= cfg_wdata;
            if (cfg_addr == LO_SEL) tbl_lo[i] <= cfg_wdata[WORD_W-1 -: LO_KEEP_W];
         end
      end

      p_lo_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_we && cfg_addr == LO_SEL) |=> tbl_lo[i] == $past(cfg_wdata[WORD_W-1 -: LO_KEEP_W]))
         else $error("p_lo_upper_r2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ent_en <= '0;
         ctl    <= '0;
      end else if (cfg_we) begin
         if (cfg_addr == CFG_AW'(EN_SEL))  ent_en <= cfg_wdata[N_ENTRIES-1:0];
         if (cfg_addr == CFG_AW'(CTL_SEL)) ctl    <= afc_ctl_t'(cfg_wdata[CTL_W-1:0]);
      end
   end

   p_en_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == CFG_AW'(EN_SEL)) |=> ent_en == $past(cfg_wdata[N_ENTRIES-1:0]))
      else $error("p_en_write_r3");

   p_ctl_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_we && cfg_addr == CFG_AW'(CTL_SEL)) |=> $stable(ctl))
      else $error("p_ctl_hold_r4");
endmodule

// File: rtl/afc_octet_asm.sv
`timescale 1ns/1ps
module afc_octet_asm (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            oct_vld,
   input  logic                            oct_sof,
   input  logic [afc_pkg::OCTET_W-1:0]     oct_data,
   output logic                            addr_vld,
   output logic [afc_pkg::MAC_W-1:0]       addr
);
   import afc_pkg::*;

   localparam int unsigned LAST   = OCTET_CNT - 1;
   localparam int unsigned CNT_W  = $clog2(OCTET_CNT);
   localparam int unsigned HELD_W = MAC_W - OCTET_W;

   // cnt 0: idle, 1..LAST: number of octets already held
   logic [CNT_W-1:0]  cnt;
   logic [HELD_W-1:0] held;

   always_comb begin
      addr_vld = oct_vld && !oct_sof && (cnt == CNT_W'(LAST));
      addr     = {held, oct_data};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         held <= '0;
      end else if (oct_vld) begin
         if (oct_sof) begin
            cnt  <= CNT_W'(1);
            held <= HELD_W'(oct_data);
         end else if (cnt != '0) begin
            held <= {held[HELD_W-OCTET_W-1:0], oct_data};
            cnt  <= (cnt == CNT_W'(LAST)) ? '0 : cnt + CNT_W'(1);
         end
      end
   end

   p_cnt_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(LAST))
      else $error("p_cnt_range_r10");

   p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (oct_vld && oct_sof) |=> cnt == CNT_W'(1))
      else $error("p_restart_r11");

   p_idle_stays_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0 && !(oct_vld && oct_sof)) |=> cnt == '0)
      else $error("p_idle_stays_r11");
endmodule

// File: rtl/afc_match.sv
`timescale 1ns/1ps
module afc_match #(
   parameter int unsigned N_ENTRIES = 16,
   parameter int unsigned IDX_W     = 4
) (
   input  logic                                          clk,
   input  logic                                          rst_n,
   input  logic [afc_pkg::MAC_W-1:0]                     addr,
   input  logic [N_ENTRIES-1:0][afc_pkg::WORD_W-1:0]     tbl_hi,
   input  logic [N_ENTRIES-1:0][afc_pkg::LO_KEEP_W-1:0]  tbl_lo,
   input  logic [N_ENTRIES-1:0]                          ent_en,
   output logic                                          any_hit,
   output logic [IDX_W-1:0]                              hit_idx
);
   import afc_pkg::*;

   logic [N_ENTRIES-1:0] hit_vec;
   logic [N_ENTRIES-1:0] grant;

   for (genvar i = 0; i < N_ENTRIES; i++) begin : g_cmp
      assign hit_vec[i] = ent_en[i]
                        && (tbl_hi[i] == addr[MAC_W-1 -: WORD_W])
                        && (tbl_lo[i] == addr[LO_KEEP_W-1:0]);
   end

   // isolate the lowest set bit: lowest index wins
   always_comb begin
      grant   = hit_vec & (~hit_vec + N_ENTRIES'(1));
      any_hit = |hit_vec;
      hit_idx = '0;
      for (int i = 0; i < N_ENTRIES; i++) begin
         if (grant[i]) hit_idx = hit_idx | IDX_W'(i);
      end
   end

   p_grant_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant))
      else $error("p_grant_onehot_r8");

   p_grant_present_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|hit_vec) == (|grant))
      else $error("p_grant_present_r8");

   p_grant_subset_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~ent_en) == '0)
      else $error("p_grant_subset_r3");
endmodule

// File: rtl/addr_filter_cam.sv
`timescale 1ns/1ps
module addr_filter_cam #(
   parameter int unsigned N_ENTRIES = 16,
   parameter bit          SERIAL_EN = 1'b1,
   localparam int unsigned CFG_AW   = $clog2(2 * N_ENTRIES + 2),
   localparam int unsigned IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_we,
   input  logic [CFG_AW-1:0]     cfg_addr,
   input  logic [31:0]           cfg_wdata,
   input  logic                  da_vld,
   input  logic [47:0]           da,
   input  logic                  rx_vld,
   input  logic                  rx_sof,
   input  logic [7:0]            rx_byte,
   output logic                  dec_vld,
   output logic                  dec_accept,
   output logic                  dec_hit,
   output logic [IDX_W-1:0]      dec_idx
);
   import afc_pkg::*;

   if (N_ENTRIES < 1 || N_ENTRIES > WORD_W) begin : g_size_chk
      $error("addr_filter_cam: N_ENTRIES must lie in 1..32");
   end
   if (MAC_W != 48 || OCTET_CNT != 6) begin : g_fmt_chk
      $error("addr_filter_cam: address format constants inconsistent");
   end

   logic [N_ENTRIES-1:0][WORD_W-1:0]    tbl_hi;
   logic [N_ENTRIES-1:0][LO_KEEP_W-1:0] tbl_lo;
   logic [N_ENTRIES-1:0]                ent_en;
   afc_ctl_t                            ctl;

   afc_table #(.N_ENTRIES(N_ENTRIES), .CFG_AW(CFG_AW)) u_table (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .tbl_hi(tbl_hi), .tbl_lo(tbl_lo), .ent_en(ent_en), .ctl(ctl)
   );

   logic             asm_vld;
   logic [MAC_W-1:0] asm_addr;

   if (SERIAL_EN) begin : g_serial
      afc_octet_asm u_asm (
         .clk(clk), .rst_n(rst_n),
         .oct_vld(rx_vld), .oct_sof(rx_sof), .oct_data(rx_byte),
         .addr_vld(asm_vld), .addr(asm_addr)
      );
   end else begin : g_no_serial
      assign asm_vld  = 1'b0;
      assign asm_addr = '0;
   end

   // parallel strobe takes precedence over a completing serial address
   logic             lk_vld;
   logic [MAC_W-1:0] lk_addr;
   always_comb begin
      lk_vld  = da_vld || asm_vld;
      lk_addr = da_vld ? da : asm_addr;
   end

   logic             m_any;
   logic [IDX_W-1:0] m_idx;

   afc_match #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_match (
      .clk(clk), .rst_n(rst_n),
      .addr(lk_addr), .tbl_hi(tbl_hi), .tbl_lo(tbl_lo), .ent_en(ent_en),
      .any_hit(m_any), .hit_idx(m_idx)
   );

   logic             nx_hit;
   logic             nx_acc;
   logic [IDX_W-1:0] nx_idx;

   always_comb begin
      nx_hit = ctl.cmp_en && m_any;
      nx_acc = nx_hit
             || (ctl.all_bcast && addr_is_bcast(lk_addr))
             || (ctl.all_mcast && addr_is_mcast(lk_addr));
      nx_idx = nx_hit ? m_idx : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_vld    <= 1'b0;
         dec_accept <= 1'b0;
         dec_hit    <= 1'b0;
         dec_idx    <= '0;
      end else begin
         dec_vld    <= lk_vld;
         dec_accept <= lk_vld && nx_acc;
         dec_hit    <= lk_vld && nx_hit;
         dec_idx    <= lk_vld ? nx_idx : '0;
      end
   end

   p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (da_vld || asm_vld) |=> dec_vld)
      else $error("p_latency_r9");

   p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(da_vld || asm_vld) |=> (!dec_vld && !dec_accept && !dec_hit && dec_idx == '0))
      else $error("p_quiet_r9");

   p_hit_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dec_hit |-> dec_accept)
      else $error("p_hit_keeps_r7");

   p_cmp_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dec_hit |-> $past(ctl.cmp_en))
      else $error("p_cmp_gate_r7");

   p_idx_nohit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_hit |-> dec_idx == '0)
      else $error("p_idx_nohit_r8");

   p_par_first_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (da_vld && ctl.all_bcast && (&da)) |=> dec_accept)
      else $error("p_par_first_r12");
endmodule

// File: tb/tb_addr_filter_cam.sv
`timescale 1ns/1ps
module tb_addr_filter_cam;
   localparam int N   = 16;
   localparam int AW  = 6;
   localparam int ENR = 2 * N;
   localparam int CTR = 2 * N + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [AW-1:0] cfg_addr = '0;
   logic [31:0]   cfg_wdata = '0;
   logic          da_vld = 1'b0;
   logic [47:0]   da = '0;
   logic          rx_vld = 1'b0;
   logic          rx_sof = 1'b0;
   logic [7:0]    rx_byte = '0;
   logic          dec_vld, dec_accept, dec_hit;
   logic [3:0]    dec_idx;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   addr_filter_cam dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .da_vld(da_vld), .da(da),
      .rx_vld(rx_vld), .rx_sof(rx_sof), .rx_byte(rx_byte),
      .dec_vld(dec_vld), .dec_accept(dec_accept), .dec_hit(dec_hit), .dec_idx(dec_idx)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [47:0] m_addr [N];
   logic        m_en   [N];
   logic [2:0]  m_ctl;
   int          m_cnt;
   logic [47:0] m_buf;
   logic        e_vld, e_acc, e_hit;
   int          e_idx;
   bit          model_on = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin m_addr[i] = '0; m_en[i] = 0; end
         m_ctl = '0; m_cnt = 0; m_buf = '0;
         e_vld = 0; e_acc = 0; e_hit = 0; e_idx = 0;
      end else begin
         logic        sdone;
         logic [47:0] look;
         sdone = 0;
         if (rx_vld) begin
            if (rx_sof) begin
               m_buf = {rx_byte, 40'h0}; m_cnt = 1;
            end else if (m_cnt > 0) begin
               m_buf[47 - 8*m_cnt -: 8] = rx_byte;
               m_cnt++;
               if (m_cnt == 6) begin sdone = 1; m_cnt = 0; end
            end
         end
         e_vld = da_vld || sdone;
         look  = da_vld ? da : m_buf;
         e_hit = 0; e_idx = 0;
         if (e_vld && m_ctl[0]) begin
            for (int i = N - 1; i >= 0; i--)
               if (m_en[i] && m_addr[i] == look) begin e_hit = 1; e_idx = i; end
         end
         e_acc = e_vld && (e_hit || (m_ctl[2] && look == '1) || (m_ctl[1] && look[40]));
         if (cfg_we) begin
            if (cfg_addr < ENR) begin
               if (cfg_addr[0]) m_addr[cfg_addr >> 1][15:0]  = cfg_wdata[31:16];
               else             m_addr[cfg_addr >> 1][47:16] = cfg_wdata;
            end else if (cfg_addr == ENR) begin
               for (int i = 0; i < N; i++) m_en[i] = cfg_wdata[i];
            end else if (cfg_addr == CTR) begin
               m_ctl = cfg_wdata[2:0];
            end
         end
      end
   end

   always @(negedge clk) begin
      if (model_on) begin
         chk("R9 model dec_vld", dec_vld, e_vld);
         chk("R7 model dec_accept", dec_accept, e_acc);
         chk("R7 model dec_hit", dec_hit, e_hit);
         chk("R8 model dec_idx", dec_idx, e_idx);
      end
   end

   // ---------------- stimulus helpers (start and end at negedge) ----------------
   task automatic wr(input int idx, input logic [31:0] d);
      cfg_we = 1; cfg_addr = AW'(idx); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 0;
   endtask

   task automatic prog(input int slot, input logic [47:0] a);
      wr(2 * slot, a[47:16]);
      wr(2 * slot + 1, {a[15:0], 16'hBEEF});
   endtask

   task automatic look(input logic [47:0] a);
      da_vld = 1; da = a;
      @(negedge clk);
      da_vld = 0;
   endtask

   task automatic ser(input logic [7:0] b, input logic sof);
      rx_vld = 1; rx_byte = b; rx_sof = sof;
      @(negedge clk);
      rx_vld = 0; rx_sof = 0;
   endtask

   task automatic ser_addr(input logic [47:0] a);
      ser(a[47:40], 1);
      for (int k = 1; k < 6; k++) ser(a[47 - 8*k -: 8], 0);
   endtask

   task automatic verdict(input string tag, input logic acc, input logic hit, input int idx);
      chk({tag, " vld"}, dec_vld, 1);
      chk({tag, " accept"}, dec_accept, acc);
      chk({tag, " hit"}, dec_hit, hit);
      chk({tag, " idx"}, dec_idx, idx);
   endtask

   localparam logic [47:0] A0  = 48'h0211_2233_4455;
   localparam logic [47:0] A59 = 48'h0A0B_0C0D_0E0F;
   localparam logic [47:0] A15 = 48'h8EAA_BBCC_DDEE;
   localparam logic [47:0] BC  = 48'hFFFF_FFFF_FFFF;
   localparam logic [47:0] MC  = 48'h0100_5E00_0001;

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      model_on = 1;
      // R1 reset state
      chk("R1 reset dec_vld", dec_vld, 0);
      look(48'h0);
      verdict("R1 empty table", 0, 0, 0);
      look(A0);
      verdict("R1 nothing enabled", 0, 0, 0);

      // R2, R4: program slot 0, compare on with junk in unused policy bits
      prog(0, A0);
      wr(ENR, 32'h0000_0001);
      wr(CTR, 32'hFFFF_FFF9);  // bits 2:0 = 001
      look(A0);
      verdict("R2 own address", 1, 1, 0);
      look(48'h0211_2233_4456);
      verdict("R2 last octet differs", 0, 0, 0);
      look(48'h0311_2233_4455);
      verdict("R4 no mcast from junk bits", 0, 0, 0);
      look(BC);
      verdict("R4 no bcast from junk bits", 0, 0, 0);

      // R8 duplicate addresses, R3 enable bitmap
      prog(5, A59);
      prog(9, A59);
      prog(15, A15);
      wr(ENR, 32'hFFFF_8221);
      look(A59);
      verdict("R8 lowest of 5 and 9", 1, 1, 5);
      look(A15);
      verdict("R8 top slot", 1, 1, 15);
      wr(ENR, 32'h0000_8201);
      look(A59);
      verdict("R3 slot 5 disabled", 1, 1, 9);
      wr(ENR, 32'h0000_0001);
      look(A15);
      verdict("R3 slot 15 disabled", 0, 0, 0);

      // R7 compare off
      wr(CTR, 32'h0);
      look(A0);
      verdict("R7 compare off", 0, 0, 0);

      // R5 broadcast
      wr(CTR, 32'h4);
      look(BC);
      verdict("R5 broadcast kept", 1, 0, 0);
      look(MC);
      verdict("R5 multicast not kept", 0, 0, 0);
      wr(CTR, 32'h0);
      look(BC);
      verdict("R5 switch clear", 0, 0, 0);

      // R6 multicast
      wr(CTR, 32'h2);
      look(MC);
      verdict("R6 group address", 1, 0, 0);
      look(BC);
      verdict("R6 broadcast is group", 1, 0, 0);
      look(A0);
      verdict("R6 unicast", 0, 0, 0);

      // R7 combination: table plus multicast
      wr(CTR, 32'h3);
      look(A0);
      verdict("R7 hit with mcast on", 1, 1, 0);

      // R10 serial with gaps
      wr(CTR, 32'h1);
      ser(8'h02, 1);
      @(negedge clk);
      ser(8'h11, 0);
      chk("R10 no early verdict", dec_vld, 0);
      ser(8'h22, 0);
      ser(8'h33, 0);
      @(negedge clk);
      ser(8'h44, 0);
      chk("R10 no verdict at fifth", dec_vld, 0);
      ser(8'h55, 0);
      verdict("R10 serial own address", 1, 1, 0);
      // R11 trailing byte
      ser(8'h66, 0);
      chk("R11 trailing byte", dec_vld, 0);
      // R10 octet order: reversed bytes do not match
      ser(8'h55, 1); ser(8'h44, 0); ser(8'h33, 0);
      ser(8'h22, 0); ser(8'h11, 0); ser(8'h02, 0);
      verdict("R10 reversed order", 0, 0, 0);
      // R11 bytes with no start flag
      for (int k = 0; k < 6; k++) begin
         ser(A0[47 - 8*k -: 8], 0);
         chk("R11 no sof", dec_vld, 0);
      end
      // R11 restart part-way
      ser(8'hAA, 1);
      ser(8'hBB, 0);
      ser_addr(A0);
      verdict("R11 restart", 1, 1, 0);

      // R12 parallel and serial complete together
      wr(CTR, 32'h5);
      ser(8'h02, 1); ser(8'h11, 0); ser(8'h22, 0); ser(8'h33, 0); ser(8'h44, 0);
      rx_vld = 1; rx_byte = 8'h55; da_vld = 1; da = BC;
      @(negedge clk);
      rx_vld = 0; da_vld = 0;
      verdict("R12 parallel judged", 1, 0, 0);
      @(negedge clk);
      chk("R12 single pulse", dec_vld, 0);

      // R9 same-cycle write uses old table
      cfg_we = 1; cfg_addr = AW'(ENR); cfg_wdata = 32'h0;
      da_vld = 1; da = A0;
      @(negedge clk);
      cfg_we = 0; da_vld = 0;
      verdict("R9 old table used", 1, 1, 0);
      look(A0);
      verdict("R9 new table used", 0, 0, 0);
      @(negedge clk);
      chk("R9 idle outputs", {dec_vld, dec_accept, dec_hit, dec_idx}, 0);

      repeat (3) @(negedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule